// File: doc/BRIEF.md
# Two-Axis Traffic Light Sequencer

This block controls the lamps at a crossing with two axes of traffic: north-south and east-west. Both lamps on an axis always show the same colour, so the block drives three lamp enables per axis: go (green), warn (yellow) and stop (red). The controller repeats a fixed cycle of four phases. The north-south axis goes green and then yellow while east-west is held at red. Then east-west goes green and then yellow while north-south is held at red. After that the cycle starts again.

Timing is measured in ticks. A tick is a one-cycle enable pulse that the surrounding system supplies, normally once per second. The design has three parts:
- **Phase sequencer.** It holds the current phase. It does no counting of its own.
- **Phase timer.** It counts ticks and raises a long alarm, used by green phases, and a short alarm, used by yellow phases.
- **Decoder.** It turns the phase into the six lamp enables. It also produces the restart pulse that clears the timer whenever a new phase is entered.

The green and yellow lengths are parameters. The defaults are 45 and 15 ticks.

Top module: `traffic_phase_ctrl`

## Requirements
- R1: Reset is synchronous and active high. On the cycle after a reset edge, the outputs show north-south green and east-west red, and the tick count for the phase starts from zero.
- R2: The phases follow this order and then repeat forever: NS green/EW red, NS yellow/EW red, NS red/EW green, NS red/EW yellow.
- R3: A green phase lasts exactly GREEN_TICKS ticks. The lamps change on the clock edge that samples the GREEN_TICKS-th tick seen since the phase was entered.
- R4: A yellow phase lasts exactly YELLOW_TICKS ticks and changes on the same kind of edge as a green phase.
- R5: Each axis shows red for GREEN_TICKS + YELLOW_TICKS ticks, which is the other axis's green time plus its yellow time.
- R6: A cycle with the tick input low neither advances the phase nor moves the timer. The lamp outputs stay the same.
- R7: On each axis, exactly one of go, warn and stop is high in every cycle.
- R8: The two axes are never both showing go or warn at the same time.
- R9: Each phase is timed from its own entry. The tick that ends one phase is not counted towards the next phase, even when the tick input is held high on every cycle.
- R10: A reset asserted in the middle of a phase returns the block to NS green with a full GREEN_TICKS count still to run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | One-cycle tick enable, normally one per second |
| ns_go | output | 1 | North-south green lamp enable |
| ns_warn | output | 1 | North-south yellow lamp enable |
| ns_stop | output | 1 | North-south red lamp enable |
| ew_go | output | 1 | East-west green lamp enable |
| ew_warn | output | 1 | East-west yellow lamp enable |
| ew_stop | output | 1 | East-west red lamp enable |

## Verification
Two things can happen in the same cycle: the timer restart at a phase change and the tick increment. The tick that raises an alarm arrives on the very cycle in which the decoder asks for the counter to be cleared. The bench provokes this by holding tick_en high for long stretches, so that every phase boundary coincides with a tick. It judges the result by requiring that the next phase still lasts its full length, not one tick less. Sparse and stalled tick patterns then separate clock cycles from ticks, and a reset in the middle of a phase checks that the restart also follows a reset.

// File: rtl/tl_pkg.sv
package tl_pkg;

    // Three bits leave room for unused codes, which the sequencer recovers from.
    typedef enum logic [2:0] {
        PH_NS_GO   = 3'd0,
        PH_NS_WARN = 3'd1,
        PH_EW_GO   = 3'd2,
        PH_EW_WARN = 3'd3
    } phase_e;

    typedef struct packed {
        phase_e phase;
    } seq_regs_t;

    typedef struct packed {
        logic go;
        logic warn;
        logic stop;
    } lamp_t;

    localparam int AXES    = 2;
    localparam int AXIS_NS = 0;
    localparam int AXIS_EW = 1;

    function automatic phase_e go_phase_of(input int axis);
        return (axis == AXIS_NS) ? PH_NS_GO : PH_EW_GO;
    endfunction

    function automatic phase_e warn_phase_of(input int axis);
        return (axis == AXIS_NS) ? PH_NS_WARN : PH_EW_WARN;
    endfunction

endpackage

// File: rtl/tl_phase_timer.sv
module tl_phase_timer #(
    parameter int LONG_TICKS  = 45,
    parameter int SHORT_TICKS = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic restart,
    output logic long_alarm,
    output logic short_alarm
);
    localparam int MAX_TICKS = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int CW        = $clog2(MAX_TICKS + 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_TICKS - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_TICKS - 1);
    localparam logic [CW-1:0] CNT_SAT    = CW'(MAX_TICKS);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (restart) begin
            r_d.cnt = '0;
        end else if (tick_en && (r_q.cnt != CNT_SAT)) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // An alarm marks the tick that completes the interval.
    assign long_alarm  = tick_en && (r_q.cnt >= LONG_LAST);
    assign short_alarm = tick_en && (r_q.cnt >= SHORT_LAST);

endmodule

// File: rtl/tl_phase_seq.sv
module tl_phase_seq
    import tl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   long_alarm,
    input  logic   short_alarm,
    output phase_e phase,
    output logic   advance
);
    seq_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        advance = 1'b0;
        unique case (r_q.phase)
            PH_NS_GO: begin
                advance = long_alarm;
                if (long_alarm) r_d.phase = PH_NS_WARN;
            end
            PH_NS_WARN: begin
                advance = short_alarm;
                if (short_alarm) r_d.phase = PH_EW_GO;
            end
            PH_EW_GO: begin
                advance = long_alarm;
                if (long_alarm) r_d.phase = PH_EW_WARN;
            end
            PH_EW_WARN: begin
                advance = short_alarm;
                if (short_alarm) r_d.phase = PH_NS_GO;
            end
            default: begin
                advance   = 1'b1;
                r_d.phase = PH_NS_GO;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.phase <= PH_NS_GO;
        end else begin
            r_q <= r_d;
        end
    end

    assign phase = r_q.phase;

endmodule

// File: rtl/tl_lamp_decode.sv
module tl_lamp_decode
    import tl_pkg::*;
(
    input  phase_e                phase,
    input  logic                  advance,
    output lamp_t [AXES-1:0]      lamps,
    output logic                  timer_restart
);
    for (genvar ax = 0; ax < AXES; ax++) begin : g_axis
        always_comb begin
            lamps[ax].go   = (phase == go_phase_of(ax));
            lamps[ax].warn = (phase == warn_phase_of(ax));
            lamps[ax].stop = !(lamps[ax].go || lamps[ax].warn);
        end
    end

    // Clear the timer on the edge that enters the next phase.
    assign timer_restart = advance;

endmodule

// File: rtl/traffic_phase_ctrl.sv
module traffic_phase_ctrl #(
    parameter int GREEN_TICKS  = 45,
    parameter int YELLOW_TICKS = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    output logic ns_go,
    output logic ns_warn,
    output logic ns_stop,
    output logic ew_go,
    output logic ew_warn,
    output logic ew_stop
);
    import tl_pkg::*;

    logic                 long_alarm;
    logic                 short_alarm;
    logic                 advance;
    logic                 timer_restart;
    phase_e               phase;
    lamp_t [AXES-1:0]     lamps;

    tl_phase_timer #(
        .LONG_TICKS  (GREEN_TICKS),
        .SHORT_TICKS (YELLOW_TICKS)
    ) timer_i (
        .clk         (clk),
        .rst         (rst),
        .tick_en     (tick_en),
        .restart     (timer_restart),
        .long_alarm  (long_alarm),
        .short_alarm (short_alarm)
    );

    tl_phase_seq seq_i (
        .clk         (clk),
        .rst         (rst),
        .long_alarm  (long_alarm),
        .short_alarm (short_alarm),
        .phase       (phase),
        .advance     (advance)
    );

    tl_lamp_decode dec_i (
        .phase         (phase),
        .advance       (advance),
        .lamps         (lamps),
        .timer_restart (timer_restart)
    );

    assign ns_go   = lamps[AXIS_NS].go;
    assign ns_warn = lamps[AXIS_NS].warn;
    assign ns_stop = lamps[AXIS_NS].stop;
    assign ew_go   = lamps[AXIS_EW].go;
    assign ew_warn = lamps[AXIS_EW].warn;
    assign ew_stop = lamps[AXIS_EW].stop;

endmodule

// File: rtl/tl_ctrl_chk.sv
module tl_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic tick_en,
    input logic ns_go,
    input logic ns_warn,
    input logic ns_stop,
    input logic ew_go,
    input logic ew_warn,
    input logic ew_stop
);
    AST_RESET_NS_GREEN: assert property (@(posedge clk)
        rst |=> (ns_go && ew_stop)); // R1

    AST_ORDER_NS_GO: assert property (@(posedge clk) disable iff (rst)
        ns_go |=> (ns_go || ns_warn)); // R2

    AST_ORDER_NS_WARN: assert property (@(posedge clk) disable iff (rst)
        ns_warn |=> (ns_warn || ew_go)); // R2

    AST_ORDER_EW_GO: assert property (@(posedge clk) disable iff (rst)
        ew_go |=> (ew_go || ew_warn)); // R2

    AST_ORDER_EW_WARN: assert property (@(posedge clk) disable iff (rst)
        ew_warn |=> (ew_warn || ns_go)); // R2

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable({ns_go, ns_warn, ns_stop, ew_go, ew_warn, ew_stop})); // R6

    AST_ONE_LAMP_NS: assert property (@(posedge clk) disable iff (rst)
        $countones({ns_go, ns_warn, ns_stop}) == 1); // R7

    AST_ONE_LAMP_EW: assert property (@(posedge clk) disable iff (rst)
        $countones({ew_go, ew_warn, ew_stop}) == 1); // R7

    AST_NO_CONFLICT: assert property (@(posedge clk) disable iff (rst)
        !((ns_go || ns_warn) && (ew_go || ew_warn))); // R8

endmodule

bind traffic_phase_ctrl tl_ctrl_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .ns_go   (ns_go),
    .ns_warn (ns_warn),
    .ns_stop (ns_stop),
    .ew_go   (ew_go),
    .ew_warn (ew_warn),
    .ew_stop (ew_stop)
);

// File: tb/traffic_phase_ctrl_tb_top.sv
module traffic_phase_ctrl_tb_top;

    localparam int G = 4;
    localparam int Y = 2;

    typedef struct {
        logic [5:0] lamps;   // {ns_go, ns_warn, ns_stop, ew_go, ew_warn, ew_stop}
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_en = 1'b0;
    logic ns_go, ns_warn, ns_stop, ew_go, ew_warn, ew_stop;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    exp_t exp_q[$];

    // Reference model state, kept only in terms of the requirements.
    int m_phase = 0;
    int m_ticks = 0;

    always #2 clk = ~clk;

    traffic_phase_ctrl #(
        .GREEN_TICKS  (G),
        .YELLOW_TICKS (Y)
    ) dut_i (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .ns_go   (ns_go),
        .ns_warn (ns_warn),
        .ns_stop (ns_stop),
        .ew_go   (ew_go),
        .ew_warn (ew_warn),
        .ew_stop (ew_stop)
    );

    function automatic logic [5:0] lamps_of(input int ph);
        case (ph)
            0:       return 6'b100_001;
            1:       return 6'b010_001;
            2:       return 6'b001_100;
            default: return 6'b001_010;
        endcase
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the lamps expected after the edge.
    task automatic step(input logic r, input logic t, input string tag);
        exp_t e;
        @(negedge clk);
        rst     = r;
        tick_en = t;
        if (r) begin
            m_phase = 0;
            m_ticks = 0;
        end else if (t) begin
            m_ticks++;
            if (m_ticks == (((m_phase % 2) == 0) ? G : Y)) begin
                m_phase = (m_phase + 1) % 4;
                m_ticks = 0;
            end
        end
        e.lamps = lamps_of(m_phase);
        e.tag   = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compares outputs shortly after each active edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                logic [5:0] act;
                e   = exp_q.pop_front();
                act = {ns_go, ns_warn, ns_stop, ew_go, ew_warn, ew_stop};
                checks++;
                if (act !== e.lamps) begin
                    errors++;
                    $display("FAIL %s lamps actual=%b expected=%b at %0t", e.tag, act, e.lamps, $time);
                end
                checks++;
                if (($countones(act[5:3]) != 1) || ($countones(act[2:0]) != 1)) begin
                    errors++;
                    $display("FAIL R7 one lamp per axis actual=%b expected=one-hot per axis", act);
                end
                checks++;
                if ((act[5] || act[4]) && (act[2] || act[1])) begin
                    errors++;
                    $display("FAIL R8 axis conflict actual=%b expected=one axis red", act);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        // R1: reset state
        step(1'b1, 1'b0, "R1");
        step(1'b1, 1'b1, "R1");
        // R1 R3: full green count from reset, ticks every cycle (R9 boundary with tick high)
        for (int i = 0; i < 3 * (2 * (G + Y)); i++) step(1'b0, 1'b1, "R2 R3 R4 R5 R9");
        // R6: stall with no ticks
        for (int i = 0; i < 8; i++) step(1'b0, 1'b0, "R6");
        // Sparse ticks, one every third cycle
        for (int i = 0; i < 90; i++) step(1'b0, (i % 3) == 0, "R3 R4 R5 R6");
        // Alternate ticks
        for (int i = 0; i < 40; i++) step(1'b0, (i % 2) == 1, "R2 R9");
        // R10: reset in the middle of a phase, then a full green must follow
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R2");
        step(1'b1, 1'b1, "R10");
        for (int i = 0; i < 2 * (G + Y) + 4; i++) step(1'b0, 1'b1, "R10 R1");
        // Drain the scoreboard
        while (exp_q.size() > 0) @(posedge clk);
        @(negedge clk);
        summary();
    end

endmodule